// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell software which kind of reset or wake-up happened last. A power-control register holds a power-on flag, a brown-out flag and two control bits. A status register holds a time-out flag and a power-down flag, together with plain bank and arithmetic storage bits that are kept here only for their reset values.

Hardware clears the flags and software re-arms them by writing 1. Each event input leaves a different pattern of cleared, set and unchanged flags, so a later read tells the reset sources apart. The events are power-on, brown-out, watchdog time-out, external reset and sleep entry. Power-on is the block's asynchronous active-low reset. The other events are single-cycle pulses. The block tracks whether the device is asleep, so a watchdog or external event can be read as a wake from sleep rather than a reset during normal running. Software reaches both registers through an address/data port with a combinational read.

Top module: `rst_cause_regs`

## Requirements
- R1: While and after `porN` is low, the power-control register reads 8'h10 (control bits 5:4 = 2'b01, power-on flag bit 1 = 0, brown-out flag bit 0 = 0, which models the undefined value). The status register reads 8'h18 (bits 7:5 = 0, time-out bit 4 = 1, power-down bit 3 = 1, bits 2:0 = 0). The device is awake.
- R2: A brown-out pulse sets the power-on flag to 1, clears the brown-out flag, sets time-out and power-down to 1, clears status bits 7:5, loads control bits 5:4 with 2'b01, leaves status bits 2:0 unchanged and wakes the device.
- R3: A watchdog pulse while awake clears time-out, clears status bits 7:5 and control bit 5. It leaves power-down, the power-on flag, the brown-out flag, control bit 4 and status bits 2:0 unchanged.
- R4: A watchdog pulse while asleep is a wake-up. It clears both time-out and power-down, changes no other bit and leaves sleep.
- R5: An external reset pulse while awake leaves time-out, power-down, the power-on and brown-out flags, control bit 4 and status bits 2:0 unchanged. It clears status bits 7:5 and control bit 5.
- R6: An external reset pulse while asleep sets time-out to 1, clears power-down, clears status bits 7:5 and control bit 5, and leaves sleep.
- R7: A sleep command sets time-out to 1, clears power-down and enters the asleep state. No other bit changes.
- R8: Writing the status register stores bits 7:5 and 2:0, and write data bits 4:3 are ignored. Writing the power-control register stores bits 5:4 and 1:0. Bits 7:6 and 3:2 of the power-control register always read 0.
- R9: The read port returns the status register at `STATUS_ADDR`, the power-control register at `PCON_ADDR` and 0 at any other address.
- R10: When events coincide, the order of precedence is brown-out, then watchdog, then external reset, then sleep, and only the first acts. A register write in the same cycle as any event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| bodEvt | input | 1 | Brown-out reset pulse |
| wdtEvt | input | 1 | Watchdog time-out pulse |
| extEvt | input | 1 | External reset pulse |
| sleepCmd | input | 1 | Sleep entry pulse |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from regAddr |

## Verification
The bench builds the block with a 4-bit address, the status register at 3 and the power-control register at 14. With these values a random address lands on a mapped register often, while unmapped reads stay common, so random writes change both registers all the time. Random event pulses, including coincident ones, then hit many different flag combinations, both awake and asleep. The brown-out flag and arithmetic bits stay masked from comparison until they have a defined value.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int DATA_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic bor;       // brown-out load
    logic otherRst;  // watchdog/external reset class
    logic toSet;
    logic toClr;
    logic pdSet;
    logic pdClr;
    logic wrStatus;
    logic wrPcon;
  } rc_strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 'h8E
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              bodEvt,
  input  logic              wdtEvt,
  input  logic              extEvt,
  input  logic              sleepCmd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output rc_strobe_t        stb
);
  logic asleep;
  logic doBor, doWdt, doExt, doSlp, anyEvt;

  // fixed precedence among coincident events
  always_comb begin
    doBor  = bodEvt;
    doWdt  = !bodEvt && wdtEvt;
    doExt  = !bodEvt && !wdtEvt && extEvt;
    doSlp  = !bodEvt && !wdtEvt && !extEvt && sleepCmd;
    anyEvt = bodEvt || wdtEvt || extEvt || sleepCmd;
  end

  always_comb begin
    stb          = '0;
    stb.bor      = doBor;
    stb.otherRst = (doWdt && !asleep) || doExt;
    stb.toSet    = doBor || (doExt && asleep) || doSlp;
    stb.toClr    = doWdt;
    stb.pdSet    = doBor;
    stb.pdClr    = (doWdt && asleep) || (doExt && asleep) || doSlp;
    stb.wrStatus = regWrEn && !anyEvt && (regAddr == STATUS_ADDR);
    stb.wrPcon   = regWrEn && !anyEvt && (regAddr == PCON_ADDR);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) asleep <= 1'b0;
    else if (doSlp) asleep <= 1'b1;
    else if (doBor || doWdt || doExt) asleep <= 1'b0;
  end

  // R10
  evt_blocks_write_chk: assert property (@(posedge clk) disable iff (!porN)
    anyEvt |-> !stb.wrStatus && !stb.wrPcon);

  // R7
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!porN)
    (sleepCmd && !bodEvt && !wdtEvt && !extEvt) |=> asleep);

  // R6
  leave_sleep_chk: assert property (@(posedge clk) disable iff (!porN)
    (bodEvt || wdtEvt || extEvt) |=> !asleep);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 'h8E
) (
  input  logic              clk,
  input  logic              porN,
  input  rc_strobe_t        stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  logic [2:0] bankBits;
  logic [2:0] arithBits;
  logic       toFlag, pdFlag;
  logic [1:0] pctl;
  logic       porFlag, bodFlag;
  logic [DATA_W-1:0] statusVal, pconVal;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      bankBits  <= '0;
      arithBits <= '0;
      toFlag    <= 1'b1;
      pdFlag    <= 1'b1;
      pctl      <= 2'b01;
      porFlag   <= 1'b0;
      bodFlag   <= 1'b0;
    end else begin
      if (stb.bor) begin
        bankBits <= '0;
        pctl     <= 2'b01;
        porFlag  <= 1'b1;
        bodFlag  <= 1'b0;
      end else if (stb.otherRst) begin
        bankBits <= '0;
        pctl[1]  <= 1'b0;
      end
      if (stb.toSet) toFlag <= 1'b1;
      else if (stb.toClr) toFlag <= 1'b0;
      if (stb.pdSet) pdFlag <= 1'b1;
      else if (stb.pdClr) pdFlag <= 1'b0;
      if (stb.wrStatus) begin
        bankBits  <= regWrData[7:5];
        arithBits <= regWrData[2:0];
      end
      if (stb.wrPcon) begin
        pctl    <= regWrData[5:4];
        porFlag <= regWrData[1];
        bodFlag <= regWrData[0];
      end
    end
  end

  always_comb begin
    statusVal = {bankBits, toFlag, pdFlag, arithBits};
    pconVal   = {2'b00, pctl, 2'b00, porFlag, bodFlag};
    if (regAddr == STATUS_ADDR) regRdData = statusVal;
    else if (regAddr == PCON_ADDR) regRdData = pconVal;
    else regRdData = '0;
  end

  // R2
  bor_flags_chk: assert property (@(posedge clk) disable iff (!porN)
    stb.bor |=> porFlag && !bodFlag && toFlag && pdFlag && (pctl == 2'b01));

  // R3
  wdt_clears_to_chk: assert property (@(posedge clk) disable iff (!porN)
    stb.toClr |=> !toFlag);

  // R8
  ro_flags_chk: assert property (@(posedge clk) disable iff (!porN)
    !(stb.toSet || stb.toClr || stb.pdSet || stb.pdClr)
      |=> $stable(toFlag) && $stable(pdFlag));

  // R5
  keep_cause_chk: assert property (@(posedge clk) disable iff (!porN)
    (!stb.bor && !stb.wrPcon) |=> $stable(porFlag) && $stable(bodFlag));

  // R8
  pcon_unimpl_chk: assert property (@(posedge clk) disable iff (!porN)
    (regAddr == PCON_ADDR) |-> (regRdData & 8'hCC) == 8'h00);
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] PCON_ADDR = 'h8E
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              bodEvt,
  input  logic              wdtEvt,
  input  logic              extEvt,
  input  logic              sleepCmd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData
);
  rc_strobe_t stb;

  rst_cause_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .PCON_ADDR(PCON_ADDR)) u_ctrl (
    .clk(clk), .porN(porN), .bodEvt(bodEvt), .wdtEvt(wdtEvt), .extEvt(extEvt),
    .sleepCmd(sleepCmd), .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  rst_cause_dp #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .PCON_ADDR(PCON_ADDR)) u_dp (
    .clk(clk), .porN(porN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );
endmodule

// File: tb/sim_rst_cause_regs.sv
module sim_rst_cause_regs;
  localparam int AW = 4;
  localparam logic [AW-1:0] SA = 4'd3;
  localparam logic [AW-1:0] PA = 4'd14;

  logic clk = 0;
  logic porN = 0;
  logic bodEvt = 0, wdtEvt = 0, extEvt = 0, sleepCmd = 0;
  logic [AW-1:0] regAddr = '0;
  logic regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model
  logic [2:0] mBank, mArith;
  logic mTo, mPd, mPor, mBod, mSleep;
  logic [1:0] mCtl;
  bit bodKnown, arithKnown;

  always #5 clk = ~clk;

  rst_cause_regs #(.ADDR_W(AW), .STATUS_ADDR(SA), .PCON_ADDR(PA)) u0 (
    .clk(clk), .porN(porN), .bodEvt(bodEvt), .wdtEvt(wdtEvt), .extEvt(extEvt),
    .sleepCmd(sleepCmd), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [7:0] expStatus();
    return {mBank, mTo, mPd, mArith};
  endfunction
  function automatic logic [7:0] expPcon();
    return {2'b00, mCtl, 2'b00, mPor, mBod};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
    total++;
    if ((act & mask) !== (exp & mask)) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (mask %h)", req, act, exp, mask);
    end
  endtask

  task automatic modelPor();
    mBank = 0; mArith = 0; mTo = 1; mPd = 1; mCtl = 2'b01;
    mPor = 0; mBod = 0; mSleep = 0; bodKnown = 0; arithKnown = 0;
  endtask

  function automatic string modelStep(bit b, bit w, bit e, bit s, bit we,
                                      logic [AW-1:0] a, logic [7:0] d);
    string tag;
    tag = "R9";
    if (b) begin
      mBank = 0; mCtl = 2'b01; mPor = 1; mBod = 0; mTo = 1; mPd = 1; mSleep = 0;
      bodKnown = 1; tag = (w || e || s || we) ? "R10" : "R2";
    end else if (w) begin
      if (mSleep) begin mTo = 0; mPd = 0; tag = "R4"; end
      else begin mTo = 0; mBank = 0; mCtl[1] = 0; tag = "R3"; end
      mSleep = 0;
      if (e || s || we) tag = "R10";
    end else if (e) begin
      mBank = 0; mCtl[1] = 0;
      if (mSleep) begin mTo = 1; mPd = 0; tag = "R6"; end
      else tag = "R5";
      mSleep = 0;
      if (s || we) tag = "R10";
    end else if (s) begin
      mTo = 1; mPd = 0; mSleep = 1; tag = we ? "R10" : "R7";
    end else if (we) begin
      if (a == SA) begin mBank = d[7:5]; mArith = d[2:0]; arithKnown = 1; tag = "R8"; end
      else if (a == PA) begin mCtl = d[5:4]; mPor = d[1]; mBod = d[0]; bodKnown = 1; tag = "R8"; end
    end
    return tag;
  endfunction

  task automatic readAll(string tag);
    logic [7:0] sm, pm;
    logic [AW-1:0] ra;
    sm = arithKnown ? 8'hFF : 8'hF8;
    pm = bodKnown ? 8'hFF : 8'hFE;
    regAddr = SA; #1;
    check(tag, regRdData, expStatus(), sm);
    regAddr = PA; #1;
    check(tag, regRdData, expPcon(), pm);
    ra = AW'($urandom % 16);
    regAddr = ra; #1;
    if (ra == SA) check("R9", regRdData, expStatus(), sm);
    else if (ra == PA) check("R9", regRdData, expPcon(), pm);
    else check("R9", regRdData, 8'h00, 8'hFF);
  endtask

  task automatic step(bit b, bit w, bit e, bit s, bit we, logic [AW-1:0] a, logic [7:0] d);
    string tag;
    @(negedge clk);
    bodEvt = b; wdtEvt = w; extEvt = e; sleepCmd = s;
    regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    tag = modelStep(b, w, e, s, we, a, d);
    #1;
    bodEvt = 0; wdtEvt = 0; extEvt = 0; sleepCmd = 0; regWrEn = 0;
    readAll(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    modelPor();
    repeat (3) @(posedge clk);
    #2;
    // R1 reset values while porN is held low
    regAddr = SA; #1; check("R1", regRdData, 8'h18, 8'hFF);
    regAddr = PA; #1; check("R1", regRdData, 8'h10, 8'hFF);
    regAddr = 4'd0; #1; check("R9", regRdData, 8'h00, 8'hFF);
    @(negedge clk); porN = 1;

    // R8 directed: read-only bits ignore writes, unimplemented read 0
    step(0,0,0,0,1, SA, 8'hE7);
    step(0,0,0,0,1, PA, 8'hFF);
    step(0,0,0,0,1, SA, 8'h00);
    // R3 watchdog while awake
    step(0,1,0,0,0, SA, 8'h00);
    // R7 sleep then R4 watchdog wake
    step(0,0,0,1,0, SA, 8'h00);
    step(0,1,0,0,0, SA, 8'h00);
    // R7 sleep then R6 external during sleep
    step(0,0,0,1,0, SA, 8'h00);
    step(0,0,1,0,0, SA, 8'h00);
    // R5 external while awake
    step(0,0,0,0,1, PA, 8'h33);
    step(0,0,1,0,0, SA, 8'h00);
    // R2 brown-out
    step(1,0,0,0,0, SA, 8'h00);
    // R10 coincident events and write
    step(1,1,1,1,1, PA, 8'hFF);
    step(0,1,1,0,1, SA, 8'hFF);
    step(0,0,0,1,1, PA, 8'h00);
    step(0,0,1,1,0, SA, 8'h00);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      bit b, w, e, s, we;
      int r;
      r  = $urandom % 100;
      b  = (r < 4);
      w  = ($urandom % 100) < 8;
      e  = ($urandom % 100) < 8;
      s  = ($urandom % 100) < 10;
      we = ($urandom % 100) < 60;
      step(b, w, e, s, we, AW'($urandom % 16), 8'($urandom));
    end

    // R1 again: power-on during operation
    @(negedge clk); porN = 0; modelPor(); #2;
    regAddr = SA; #1; check("R1", regRdData, 8'h18, 8'hFF);
    regAddr = PA; #1; check("R1", regRdData, 8'h10, 8'hFF);
    @(negedge clk); porN = 1;
    step(0,1,0,0,0, SA, 8'h00); // awake after power-on: R3 path

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule